// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory Slave

This block is the target side of a two-wire serial link (a clock line and a shared, open-drain data line) in front of a small configuration memory that can be programmed in system. It runs on its own system clock and oversamples both bus lines. From them it recognises the start and stop framing conditions and checks the first byte of each transfer against a fixed device identity. It then performs one of three operations:

- A write, which takes a three-byte memory address followed by any number of data bytes.
- A read at the current internal pointer.
- A random read, which is a dummy write that sets the pointer, then a repeated start and a read.

A read can continue as a sequential burst for as long as the master acknowledges each byte. A data byte written to one reserved address erases the whole array.

The block only pulls the data line low. It never drives it high. The surrounding pad logic turns `sdaPullLow` into an open-drain output. The memory model is a register array that comes out of reset blank. An active-low serial-enable input must be held low for the bus to be seen at all.

Top module: `tws_cfgmem_slave`

## Requirements
- R1: A falling data line while the clock is high is a start. It always restarts byte framing, including as a repeated start. A rising data line while the clock is high is a stop. A stop aborts any byte in progress, and a partly received data byte is not stored.
- R2: The first byte after a start is sent MSB first. Bits 7..1 must equal 7'b1010011 (0xA6 with bit 0 clear). Bit 0 selects the direction: 1 is read, 0 is write.
- R3: The block acknowledges a matching device byte, every address byte and every write data byte by pulling the data line low for the whole ninth clock of that byte.
- R4: A write delivers the memory address as three bytes, each sent MSB first, in the order high, middle, low. The internal pointer loads the low ADDR_W bits of the 24-bit value.
- R5: Data bytes are sent LSB first in both directions.
- R6: Each stored data byte goes to the pointer location, and the pointer then increments. The pointer wraps from 2^ADDR_W-1 to 0.
- R7: A read without a preceding address returns the byte at the current pointer. A dummy write of an address, then a repeated start and a read, returns the byte at that address.
- R8: While the master acknowledges (data low in the ninth clock), reading continues at successive addresses and wraps at the end of the array. A master not-acknowledge ends the burst, and after the following stop the data line is released.
- R9: After reset every location reads 0x00 and the data line is released.
- R10: A data byte written after the address 24'hFFFFFF clears every location to 0x00. It is acknowledged and does not move the pointer.
- R11: While `serEnN` is high the data line stays released, no byte is acknowledged and the memory is not changed.
- R12: After a device byte that does not match, the block does not acknowledge and ignores all traffic until the next start.
- R13: The block only begins pulling the data line low while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| serEnN | input | 1 | Active-low serial enable |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaPullLow | output | 1 | 1 pulls the data line low (open drain) |

## Verification
The interesting coincidence is a data byte being stored in the same system cycle that the pointer wraps from the last location to zero. The same coincidence arises in a sequential read, where a new byte is fetched in the same cycle that the pointer wraps. Both are provoked deliberately. A sequential write of the whole array starts at zero and runs past the end. A two-byte write starts at the top address. A read burst starts four locations below the end. Each case is judged by reading back every affected location and comparing it with a value computed arithmetically from its address.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DEV, PH_ADDR, PH_WDATA, PH_RDATA, PH_IGNORE
  } phase_t;

  // Strobes from control to the memory datapath
  typedef struct packed {
    logic wrEn;
    logic eraseAll;
    logic ptrLoad;
    logic ptrInc;
  } memStrobe_t;
endpackage

// File: rtl/tws_edge.sv
module tws_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen,
  output logic sdaNow
);
  localparam int PIPE = SYNC_STAGES + 1;

  logic [PIPE-1:0] sclPipe;
  logic [PIPE-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PIPE-2:0], sclIn};
      sdaPipe <= {sdaPipe[PIPE-2:0], sdaIn};
    end
  end

  logic sclCur, sclOld, sdaCur, sdaOld;
  assign sclCur = sclPipe[PIPE-2];
  assign sclOld = sclPipe[PIPE-1];
  assign sdaCur = sdaPipe[PIPE-2];
  assign sdaOld = sdaPipe[PIPE-1];

  assign sclRise   = sclCur & ~sclOld;
  assign sclFall   = ~sclCur & sclOld;
  assign startSeen = sclCur & sclOld & sdaOld & ~sdaCur;
  assign stopSeen  = sclCur & sclOld & ~sdaOld & sdaCur;
  assign sdaNow    = sdaCur;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [6:0]  DEV_ID     = 7'h53,
  parameter logic [23:0] ERASE_ADDR = 24'hFFFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serEnN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              sdaNow,
  input  logic [7:0]        rdByte,
  output memStrobe_t        memSt,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [7:0]        wrData,
  output logic              sdaPullLow
);
  phase_t      phase, pendPhase;
  logic [3:0]  bitCnt;
  logic [7:0]  shReg, txByte;
  logic [15:0] addrAcc;
  logic [1:0]  addrIdx;
  logic        ackPending, eraseSel;

  logic [7:0]  rxMsb, rxLsb;
  logic [23:0] addrFull;
  logic        lastBit, ackBit, readLoad, busy;

  assign rxMsb    = {shReg[6:0], sdaNow};
  assign rxLsb    = {sdaNow, shReg[7:1]};
  assign addrFull = {addrAcc, rxMsb};
  assign loadAddr = addrFull[ADDR_W-1:0];
  assign wrData   = rxLsb;

  assign busy     = !serEnN && phase != PH_IDLE && phase != PH_IGNORE;
  assign lastBit  = busy && sclRise && bitCnt == 4'd7;
  assign ackBit   = busy && sclRise && bitCnt == 4'd8;
  // fetch a byte after a read device byte, or after a master acknowledge
  assign readLoad = ackBit && pendPhase == PH_RDATA && (phase != PH_RDATA || !sdaNow);

  always_comb begin
    memSt          = '0;
    memSt.wrEn     = lastBit && phase == PH_WDATA && !eraseSel;
    memSt.eraseAll = lastBit && phase == PH_WDATA && eraseSel;
    memSt.ptrLoad  = lastBit && phase == PH_ADDR && addrIdx == 2'd2;
    memSt.ptrInc   = memSt.wrEn || readLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      pendPhase  <= PH_IDLE;
      bitCnt     <= '0;
      shReg      <= '0;
      txByte     <= '0;
      addrAcc    <= '0;
      addrIdx    <= '0;
      ackPending <= 1'b0;
      eraseSel   <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (serEnN) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      ackPending <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (startSeen) begin
      phase      <= PH_DEV;
      bitCnt     <= '0;
      ackPending <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopSeen) begin
      phase      <= PH_IDLE;
      bitCnt     <= '0;
      ackPending <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (busy && sclRise) begin
        bitCnt <= (bitCnt == 4'd8) ? 4'd0 : 4'(bitCnt + 4'd1);
        if (bitCnt < 4'd8) shReg <= (phase == PH_WDATA) ? rxLsb : rxMsb;
        if (bitCnt == 4'd7) begin
          case (phase)
            PH_DEV: begin
              addrIdx <= '0;
              if (rxMsb[7:1] == DEV_ID) begin
                ackPending <= 1'b1;
                pendPhase  <= rxMsb[0] ? PH_RDATA : PH_ADDR;
              end else begin
                ackPending <= 1'b0;
                pendPhase  <= PH_IGNORE;
              end
            end
            PH_ADDR: begin
              ackPending <= 1'b1;
              addrAcc    <= addrFull[15:0];
              addrIdx    <= addrIdx + 2'd1;
              if (addrIdx == 2'd2) begin
                pendPhase <= PH_WDATA;
                eraseSel  <= (addrFull == ERASE_ADDR);
              end else begin
                pendPhase <= PH_ADDR;
              end
            end
            PH_WDATA: begin
              ackPending <= 1'b1;
              pendPhase  <= PH_WDATA;
            end
            default: begin
              ackPending <= 1'b0;
              pendPhase  <= PH_RDATA;
            end
          endcase
        end
        if (bitCnt == 4'd8) begin
          phase <= (phase == PH_RDATA && sdaNow) ? PH_IGNORE : pendPhase;
          if (readLoad) txByte <= rdByte;
        end
      end
      if (sclFall) begin
        if (!busy)                sdaPullLow <= 1'b0;
        else if (bitCnt == 4'd8)  sdaPullLow <= ackPending;
        else if (phase == PH_RDATA) sdaPullLow <= !txByte[bitCnt[2:0]];
        else                      sdaPullLow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        memSt,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdByte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        memArr [DEPTH];
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) memArr[i] <= 8'h00;
    end else begin
      if (memSt.eraseAll) begin
        for (int i = 0; i < DEPTH; i++) memArr[i] <= 8'h00;
      end else if (memSt.wrEn) begin
        memArr[ptr] <= wrData;
      end
      if (memSt.ptrLoad)     ptr <= loadAddr;
      else if (memSt.ptrInc) ptr <= ptr + 1'b1;
    end
  end

  assign rdByte = memArr[ptr];
endmodule

// File: rtl/tws_cfgmem_slave.sv
module tws_cfgmem_slave
  import tws_pkg::*;
#(
  parameter int          ADDR_W      = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ID      = 7'h53,
  parameter logic [23:0] ERASE_ADDR  = 24'hFFFFFF
) (
  input  logic clk,
  input  logic rstN,
  input  logic serEnN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullLow
);
  logic sclRise, sclFall, startSeen, stopSeen, sdaNow;
  memStrobe_t        memSt;
  logic [ADDR_W-1:0] loadAddr;
  logic [7:0]        wrData, rdByte;

  tws_edge #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .sdaNow(sdaNow)
  );

  tws_ctrl #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID), .ERASE_ADDR(ERASE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .serEnN(serEnN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaNow(sdaNow), .rdByte(rdByte),
    .memSt(memSt), .loadAddr(loadAddr), .wrData(wrData), .sdaPullLow(sdaPullLow)
  );

  tws_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .memSt(memSt), .loadAddr(loadAddr),
    .wrData(wrData), .rdByte(rdByte)
  );
endmodule

// File: rtl/tws_cfgmem_slave_chk.sv
module tws_cfgmem_slave_chk
  import tws_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       serEnN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input memStrobe_t st,
  input logic [7:0] rdByte
);
  assert_release_when_disabled_R11: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |=> !sdaPullLow);

  assert_no_access_disabled_R11: assert property (@(posedge clk) disable iff (!rstN)
    serEnN |-> (st == '0));

  assert_pull_starts_scl_low_R13: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  assert_erase_blanks_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.eraseAll |=> (rdByte == 8'h00));

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({st.wrEn, st.eraseAll, st.ptrLoad}) <= 1);
endmodule

bind tws_cfgmem_slave tws_cfgmem_slave_chk uChk (
  .clk(clk), .rstN(rstN), .serEnN(serEnN), .sclIn(sclIn),
  .sdaPullLow(sdaPullLow), .st(memSt), .rdByte(rdByte)
);

// File: tb/sim_tws_cfgmem_slave.sv
module sim_tws_cfgmem_slave;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int Q     = 4;

  logic clk = 1'b0, rstN = 1'b0, serEnN = 1'b1, sclM = 1'b1, sdaM = 1'b1;
  logic pull;
  wire  sdaLine;
  assign sdaLine = sdaM & ~pull;

  int nChk = 0, nBad = 0, glitch = 0;
  bit done = 1'b0;
  logic [7:0] expMem [DEPTH];

  tws_cfgmem_slave #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .serEnN(serEnN), .sclIn(sclM),
    .sdaIn(sdaLine), .sdaPullLow(pull)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic bitOut(logic b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic bitIn(output logic b);
    logic p1;
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    b = sdaLine; p1 = pull;
    waitQ();
    if (pull !== p1) glitch++;
    sclM = 1'b0; waitQ();
  endtask

  task automatic byteMsb(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(ack);
  endtask

  task automatic byteLsb(logic [7:0] v, output logic ack);
    for (int i = 0; i < 8; i++) bitOut(v[i]);
    bitIn(ack);
  endtask

  task automatic readLsb(output logic [7:0] d, input logic nack);
    for (int i = 0; i < 8; i++) bitIn(d[i]);
    bitOut(nack);
  endtask

  // start, device write byte, three address bytes (R4), acks checked (R3)
  task automatic setAddr(logic [23:0] a);
    logic ack;
    startC();
    byteMsb(8'hA6, ack); chk("R3 device ack", ack, 0);
    byteMsb(a[23:16], ack); chk("R3 addr hi ack", ack, 0);
    byteMsb(a[15:8], ack);  chk("R3 addr mid ack", ack, 0);
    byteMsb(a[7:0], ack);   chk("R4 addr lo ack", ack, 0);
  endtask

  task automatic randRead(int a, output logic [7:0] d);
    logic ack;
    setAddr(24'(a));
    startC();
    byteMsb(8'hA7, ack); chk("R7 read device ack", ack, 0);
    readLsb(d, 1'b1);
    stopC();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    serEnN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 released after reset", pull, 0);
    randRead(5, d);
    chk("R9 blank array reads zero", d, 0);

    // sequential write of the whole array from 0 (R5, R6)
    setAddr(24'h000000);
    for (int a = 0; a < DEPTH; a++) begin
      byteLsb(pat(a), ack);
      chk("R3 write data ack", ack, 0);
      expMem[a] = pat(a);
    end
    stopC();

    // random read sweep (R4, R5, R7)
    for (int a = 0; a < DEPTH; a++) begin
      randRead(a, d);
      chk("R7 random read", d, expMem[a]);
    end

    // current-address read follows previous random read (R7)
    randRead(10, d);
    startC();
    byteMsb(8'hA7, ack); chk("R7 current read ack", ack, 0);
    readLsb(d, 1'b1);
    stopC();
    chk("R7 current address read", d, expMem[11]);

    // sequential read crossing the wrap (R8)
    setAddr(24'(DEPTH - 4));
    startC();
    byteMsb(8'hA7, ack);
    for (int i = 0; i < 8; i++) begin
      readLsb(d, (i == 7));
      chk("R8 sequential read", d, expMem[(DEPTH - 4 + i) % DEPTH]);
    end
    stopC();
    repeat (4) @(negedge clk);
    chk("R8 released after nack and stop", pull, 0);

    // write crossing the top address wraps to 0 (R6)
    setAddr(24'(DEPTH - 1));
    byteLsb(8'hC3, ack); chk("R6 wrap write ack", ack, 0);
    byteLsb(8'h3C, ack); chk("R6 wrap write ack", ack, 0);
    stopC();
    expMem[DEPTH - 1] = 8'hC3;
    expMem[0] = 8'h3C;
    randRead(DEPTH - 1, d); chk("R6 top address", d, 8'hC3);
    randRead(0, d);         chk("R6 wrapped to zero", d, 8'h3C);

    // device mismatch: no ack, traffic ignored (R2, R12)
    startC();
    byteMsb(8'hA4, ack); chk("R12 mismatch no ack", ack, 1);
    byteMsb(8'h00, ack); chk("R12 ignored byte", ack, 1);
    byteMsb(8'h00, ack);
    byteMsb(8'h00, ack);
    byteLsb(8'h77, ack); chk("R12 ignored data", ack, 1);
    stopC();
    startC();
    byteMsb(8'h26, ack); chk("R2 msb mismatch no ack", ack, 1);
    stopC();
    randRead(0, d); chk("R12 memory untouched", d, expMem[0]);

    // serial enable high blocks access (R11)
    serEnN = 1'b1;
    startC();
    byteMsb(8'hA6, ack); chk("R11 disabled no ack", ack, 1);
    byteMsb(8'h00, ack); byteMsb(8'h00, ack); byteMsb(8'd30, ack);
    byteLsb(8'h99, ack); chk("R11 disabled data no ack", ack, 1);
    stopC();
    serEnN = 1'b0;
    repeat (4) @(negedge clk);
    randRead(30, d); chk("R11 memory unchanged", d, expMem[30]);

    // stop inside a data byte aborts it; pointer still loaded (R1)
    setAddr(24'd40);
    for (int i = 0; i < 4; i++) bitOut(1'b1);
    stopC();
    startC();
    byteMsb(8'hA7, ack);
    readLsb(d, 1'b1);
    stopC();
    chk("R1 aborted byte not stored", d, expMem[40]);

    // whole-array erase (R10)
    setAddr(24'hFFFFFF);
    byteLsb(8'h5A, ack); chk("R10 erase ack", ack, 0);
    stopC();
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    setAddr(24'h000000);
    startC();
    byteMsb(8'hA7, ack);
    for (int a = 0; a < DEPTH; a++) begin
      readLsb(d, (a == DEPTH - 1));
      chk("R10 erased location", d, 0);
    end
    stopC();

    chk("R13 pull steady while clock high", glitch, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule